// File: doc/BRIEF.md
# Two-Stage Channel Chaining Trigger

This block chains DMA channels in pairs. A group register names a source channel, a destination channel and the kinds of completion on the source that count. When the chosen completion occurs on the source channel, the block raises a one-cycle request on the destination channel. The destination can then start without software stepping in between the two stages. Two groups are held, and each works independently of the other. Each per-channel request output is the OR of the groups that target that channel.

Software programs the groups through a simple register port. The port takes a write with byte strobes, so the source field and the destination field can be updated by separate accesses. A combinational read port returns the stored group words. The data movers feed in four completion pulse vectors, one bit per channel: fragment done, block done, transaction done and list done. The block returns a request vector and a per-group active flag.

Channel numbers in a group register are 1-based, so hardware channel n is written as n+1. A channel field of 0 means the channel is unassigned.

Top module: `chain_trig`

## Requirements
- R1: After a synchronous reset, both group words read 0, and `chan_req` and `grp_active` are all 0.
- R2: A group word has this layout: source channel in bits 5:0 and destination channel in bits 13:8. Bits 19:16 hold the trigger select, and bits 23:20 hold the interrupt mask. Bit 24 is the enable. All other bits read as 0. Group g is at `wr_addr`/`rd_addr` value g.
- R3: `wr_be[i]` writes byte i of the addressed word. A byte whose strobe is clear keeps its value. The source and destination fields can therefore be written separately.
- R4: Take an enabled group with source field s, destination field d and trigger bit k set. If the event of kind k is high on channel s-1 at a rising edge, `chan_req[d-1]` is high for exactly that next cycle. The trigger bits are: bit 16 fragment done, bit 17 block done, bit 18 transaction done, bit 19 list done.
- R5: A group whose source or destination field is 0, or is greater than NUM_CH, never fires.
- R6: A group with bit 24 clear never fires.
- R7: When several trigger bits are set, an event of any selected kind fires the group.
- R8: These events do not fire a group: an event of a kind that is not selected, and an event on a channel other than the source.
- R9: The two groups fire independently. When both groups target the same destination in the same cycle, that destination gets a single request bit.
- R10: `grp_active[g]` is high exactly when group g is enabled and both of its channel fields lie in 1..NUM_CH.
- R11: The interrupt mask bits are stored and read back, and have no effect on firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | GAW | Group index to write |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | GAW | Group index to read |
| rd_data | output | 32 | Stored group word (combinational) |
| frag_done | input | NUM_CH | Per-channel fragment completion pulse |
| blk_done | input | NUM_CH | Per-channel block completion pulse |
| trsc_done | input | NUM_CH | Per-channel transaction completion pulse |
| list_done | input | NUM_CH | Per-channel list completion pulse |
| chan_req | output | NUM_CH | Registered request pulse per destination channel |
| grp_active | output | NUM_GRP | Group enabled with both channel fields valid |

## Verification
The assertions assume that the completion inputs and the write controls are stable around the rising edge. They also assume that `rd_addr` selects an implemented group. The bench meets these assumptions by driving every input shortly after the falling edge, and by addressing only groups 0 and 1. Configurations deliberately include zero and out-of-range channel fields, multi-bit trigger selects, and two groups that share a destination. With these configurations, the random event bursts exercise the firing and the non-firing paths that the assertions bound.

// File: rtl/chain_pkg.sv
package chain_pkg;

    localparam int WORD_W    = 32;
    localparam int CH_FW     = 6;
    localparam int TRIG_W    = 4;
    localparam int IMASK_W   = 4;
    localparam int BE_W      = WORD_W / 8;

    localparam int SRC_LSB   = 0;
    localparam int DST_LSB   = 8;
    localparam int TRIG_LSB  = 16;
    localparam int IMASK_LSB = 20;
    localparam int EN_BIT    = 24;

    typedef enum logic [1:0] {
        EV_FRAG = 2'd0,
        EV_BLK  = 2'd1,
        EV_TRSC = 2'd2,
        EV_LIST = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic               en;
        logic [IMASK_W-1:0] imask;
        logic [TRIG_W-1:0]  trig;
        logic [CH_FW-1:0]   dst;
        logic [CH_FW-1:0]   src;
    } grp_cfg_t;

    function automatic grp_cfg_t apply_write(grp_cfg_t cur, logic [BE_W-1:0] be,
                                             logic [WORD_W-1:0] d);
        grp_cfg_t n;
        n = cur;
        if (be[SRC_LSB/8])  n.src = d[SRC_LSB +: CH_FW];
        if (be[DST_LSB/8])  n.dst = d[DST_LSB +: CH_FW];
        if (be[TRIG_LSB/8]) begin
            n.trig  = d[TRIG_LSB +: TRIG_W];
            n.imask = d[IMASK_LSB +: IMASK_W];
        end
        if (be[EN_BIT/8])   n.en = d[EN_BIT];
        return n;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(grp_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SRC_LSB +: CH_FW]     = c.src;
        w[DST_LSB +: CH_FW]     = c.dst;
        w[TRIG_LSB +: TRIG_W]   = c.trig;
        w[IMASK_LSB +: IMASK_W] = c.imask;
        w[EN_BIT]               = c.en;
        return w;
    endfunction

endpackage

// File: rtl/chain_grp_reg.sv
module chain_grp_reg
    import chain_pkg::*;
#(
    parameter int GAW = 1,
    parameter int IDX = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [GAW-1:0]      wr_addr,
    input  logic [BE_W-1:0]     wr_be,
    input  logic [WORD_W-1:0]   wr_data,
    output grp_cfg_t            cfg
);

    logic hit;
    assign hit = wr_en && (wr_addr == GAW'(IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (hit) begin
            cfg <= apply_write(cfg, wr_be, wr_data);
        end
    end

endmodule

// File: rtl/chain_grp_fire.sv
module chain_grp_fire
    import chain_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  grp_cfg_t            cfg,
    input  logic [NUM_CH-1:0]   frag_done,
    input  logic [NUM_CH-1:0]   blk_done,
    input  logic [NUM_CH-1:0]   trsc_done,
    input  logic [NUM_CH-1:0]   list_done,
    output logic [NUM_CH-1:0]   dst_hit,
    output logic                active
);

    logic [NUM_CH-1:0] src_sel;
    logic [NUM_CH-1:0] dst_sel;
    logic [NUM_CH-1:0] ev_any;
    logic              src_event;

    // Field value ch+1 selects hardware channel ch; 0 and values above
    // NUM_CH match no channel at all.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign src_sel[ch] = (cfg.src == CH_FW'(ch + 1));
        assign dst_sel[ch] = (cfg.dst == CH_FW'(ch + 1));
        assign ev_any[ch]  = (cfg.trig[EV_FRAG] & frag_done[ch])
                           | (cfg.trig[EV_BLK]  & blk_done[ch])
                           | (cfg.trig[EV_TRSC] & trsc_done[ch])
                           | (cfg.trig[EV_LIST] & list_done[ch]);
    end

    assign src_event = |(src_sel & ev_any);
    assign active    = cfg.en && (|src_sel) && (|dst_sel);
    assign dst_hit   = (active && src_event) ? dst_sel : '0;

endmodule

// File: rtl/chain_trig.sv
module chain_trig
    import chain_pkg::*;
#(
    parameter  int NUM_CH  = 16,
    parameter  int NUM_GRP = 2,
    localparam int GAW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [GAW-1:0]      wr_addr,
    input  logic [3:0]          wr_be,
    input  logic [31:0]         wr_data,
    input  logic [GAW-1:0]      rd_addr,
    output logic [31:0]         rd_data,
    input  logic [NUM_CH-1:0]   frag_done,
    input  logic [NUM_CH-1:0]   blk_done,
    input  logic [NUM_CH-1:0]   trsc_done,
    input  logic [NUM_CH-1:0]   list_done,
    output logic [NUM_CH-1:0]   chan_req,
    output logic [NUM_GRP-1:0]  grp_active
);

    grp_cfg_t          cfg_q [NUM_GRP];
    logic [NUM_CH-1:0] hit   [NUM_GRP];
    logic [NUM_CH-1:0] req_d;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        chain_grp_reg #(
            .GAW (GAW),
            .IDX (g)
        ) i_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_be   (wr_be),
            .wr_data (wr_data),
            .cfg     (cfg_q[g])
        );

        chain_grp_fire #(
            .NUM_CH (NUM_CH)
        ) i_fire (
            .cfg       (cfg_q[g]),
            .frag_done (frag_done),
            .blk_done  (blk_done),
            .trsc_done (trsc_done),
            .list_done (list_done),
            .dst_hit   (hit[g]),
            .active    (grp_active[g])
        );
    end

    always_comb begin
        req_d = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            req_d = req_d | hit[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_req <= '0;
        end else begin
            chan_req <= req_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (rd_addr == GAW'(g)) begin
                rd_data = cfg_to_word(cfg_q[g]);
            end
        end
    end

endmodule

// File: rtl/chain_trig_chk.sv
module chain_trig_chk #(
    parameter  int NUM_CH  = 16,
    parameter  int NUM_GRP = 2,
    localparam int GAW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [GAW-1:0]      wr_addr,
    input  logic [3:0]          wr_be,
    input  logic [31:0]         wr_data,
    input  logic [GAW-1:0]      rd_addr,
    input  logic [31:0]         rd_data,
    input  logic [NUM_CH-1:0]   frag_done,
    input  logic [NUM_CH-1:0]   blk_done,
    input  logic [NUM_CH-1:0]   trsc_done,
    input  logic [NUM_CH-1:0]   list_done,
    input  logic [NUM_CH-1:0]   chan_req,
    input  logic [NUM_GRP-1:0]  grp_active
);

    localparam logic [31:0] RSVD_MASK = 32'hFE00_C0C0;

    a_r1_req_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (chan_req == '0));

    a_r2_reserved_bits_zero: assert property (@(posedge clk) disable iff (rst)
        ((rd_data & RSVD_MASK) == 32'h0));

    a_r3_empty_strobe_keeps_word: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_be == 4'b0000)) |=>
            ((rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data))));

    a_r8_no_event_no_req: assert property (@(posedge clk) disable iff (rst)
        ((frag_done | blk_done | trsc_done | list_done) == '0) |=> (chan_req == '0));

    a_r6_no_active_group_no_req: assert property (@(posedge clk) disable iff (rst)
        (grp_active == '0) |=> (chan_req == '0));

    a_r10_req_bounded_by_active: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(chan_req) <= $countones($past(grp_active))));

endmodule

bind chain_trig chain_trig_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_GRP (NUM_GRP)
) i_chk (.*);

// File: tb/test_chain_trig.sv
`timescale 1ns/1ps
module test_chain_trig;

    localparam int NCH  = 16;
    localparam int NGRP = 2;
    localparam int GAW  = 1;
    localparam logic [31:0] VALID = 32'h01FF_3F3F;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [GAW-1:0]    wr_addr = '0;
    logic [3:0]        wr_be = '0;
    logic [31:0]       wr_data = '0;
    logic [GAW-1:0]    rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NCH-1:0]    frag_done = '0;
    logic [NCH-1:0]    blk_done = '0;
    logic [NCH-1:0]    trsc_done = '0;
    logic [NCH-1:0]    list_done = '0;
    logic [NCH-1:0]    chan_req;
    logic [NGRP-1:0]   grp_active;

    always #10 clk = ~clk;

    chain_trig #(.NUM_CH(NCH), .NUM_GRP(NGRP)) i_chain_trig (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frag_done(frag_done), .blk_done(blk_done), .trsc_done(trsc_done),
        .list_done(list_done), .chan_req(chan_req), .grp_active(grp_active)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    logic [31:0]    m_reg [NGRP];
    logic [NCH-1:0] m_req;

    function automatic logic [NCH-1:0] model_hits();
        logic [NCH-1:0] h;
        h = '0;
        for (int g = 0; g < NGRP; g++) begin
            int s, d;
            logic [3:0] t;
            logic e;
            s = int'(m_reg[g][5:0]);
            d = int'(m_reg[g][13:8]);
            t = m_reg[g][19:16];
            if (m_reg[g][24] && s >= 1 && s <= NCH && d >= 1 && d <= NCH) begin
                e = (t[0] & frag_done[s-1]) | (t[1] & blk_done[s-1])
                  | (t[2] & trsc_done[s-1]) | (t[3] & list_done[s-1]);
                if (e) h[d-1] = 1'b1;
            end
        end
        return h;
    endfunction

    function automatic logic [NGRP-1:0] model_active();
        logic [NGRP-1:0] a;
        for (int g = 0; g < NGRP; g++) begin
            int s, d;
            s = int'(m_reg[g][5:0]);
            d = int'(m_reg[g][13:8]);
            a[g] = m_reg[g][24] && s >= 1 && s <= NCH && d >= 1 && d <= NCH;
        end
        return a;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_req = '0;
            for (int g = 0; g < NGRP; g++) m_reg[g] = '0;
        end else begin
            m_req = model_hits();
            if (wr_en && int'(wr_addr) < NGRP) begin
                for (int b = 0; b < 4; b++) begin
                    if (wr_be[b]) m_reg[wr_addr][b*8 +: 8] = wr_data[b*8 +: 8] & VALID[b*8 +: 8];
                end
            end
        end
    end

    task automatic check(string t, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({tag, " chan_req vs model"}, 32'(chan_req), 32'(m_req));
            check("R10 grp_active vs model", 32'(grp_active), 32'(model_active()));
            check("R2 rd_data vs model", rd_data, m_reg[rd_addr]);
        end
    end

    function automatic logic [31:0] mk(bit en, int imask, int trig, int dst, int src);
        return (32'(en) << 24) | (32'(imask) << 20) | (32'(trig) << 16)
             | (32'(dst) << 8) | 32'(src);
    endfunction

    task automatic wr(int g, logic [3:0] be, logic [31:0] d);
        wr_en = 1'b1; wr_addr = GAW'(g); wr_be = be; wr_data = d;
        @(negedge clk); #2;
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic rd_chk(string t, int g, logic [31:0] exp);
        rd_addr = GAW'(g);
        @(negedge clk);
        check(t, rd_data, exp);
        #2;
    endtask

    // kind: 0 frag, 1 blk, 2 trsc, 3 list
    task automatic fire_chk(string t, int kind, int ch, logic [NCH-1:0] exp);
        case (kind)
            0: frag_done[ch] = 1'b1;
            1: blk_done[ch]  = 1'b1;
            2: trsc_done[ch] = 1'b1;
            default: list_done[ch] = 1'b1;
        endcase
        @(negedge clk);
        check(t, 32'(chan_req), 32'(exp));
        #2;
        frag_done = '0; blk_done = '0; trsc_done = '0; list_done = '0;
        @(negedge clk);
        check({t, " one cycle"}, 32'(chan_req), 32'h0);
        #2;
    endtask

    task automatic rnd(int n);
        for (int i = 0; i < n; i++) begin
            frag_done = NCH'($urandom); blk_done = NCH'($urandom);
            trsc_done = NCH'($urandom); list_done = NCH'($urandom);
            rd_addr = GAW'($urandom);
            @(negedge clk); #2;
        end
        frag_done = '0; blk_done = '0; trsc_done = '0; list_done = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R4 actual=running expected=finished");
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst = 1'b0;

        tag = "R1";
        @(negedge clk);
        check("R1 chan_req after reset", 32'(chan_req), 32'h0);
        check("R1 grp_active after reset", 32'(grp_active), 32'h0);
        #2;
        rd_chk("R1 group0 after reset", 0, 32'h0);
        rd_chk("R1 group1 after reset", 1, 32'h0);

        tag = "R2";
        wr(1, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R2 reserved bits read zero", 1, 32'h01FF_3F3F);
        check("R10 src 63 out of range inactive", 32'(grp_active), 32'h0);
        wr(1, 4'hF, 32'h0);

        tag = "R4";
        wr(0, 4'hF, mk(1, 0, 4'b0001, 5, 2));
        rd_chk("R2 layout readback", 0, 32'h0101_0502);
        check("R10 group0 active", 32'(grp_active), 32'h1);
        fire_chk("R4 frag on src fires dst", 0, 1, NCH'(1) << 4);
        fire_chk("R8 unselected kind", 1, 1, '0);
        fire_chk("R8 other channel", 0, 2, '0);
        rnd(200);

        tag = "R7";
        wr(0, 4'b0100, mk(0, 0, 4'b1010, 0, 0));
        fire_chk("R7 block selected", 1, 1, NCH'(1) << 4);
        fire_chk("R7 list selected", 3, 1, NCH'(1) << 4);
        fire_chk("R7 trsc not selected", 2, 1, '0);
        rnd(200);

        tag = "R3";
        wr(0, 4'b0001, 32'hFFFF_FF07);
        rd_chk("R3 source byte only", 0, 32'h010A_0507);
        wr(0, 4'b0010, 32'h0000_0900);
        rd_chk("R3 destination byte only", 0, 32'h010A_0907);
        wr(0, 4'b0000, 32'hFFFF_FFFF);
        rd_chk("R3 no strobe no change", 0, 32'h010A_0907);
        fire_chk("R3 fields used after split writes", 1, 6, NCH'(1) << 8);

        tag = "R6";
        wr(0, 4'b1000, 32'h0);
        check("R10 disabled inactive", 32'(grp_active), 32'h0);
        fire_chk("R6 disabled never fires", 1, 6, '0);
        rnd(100);

        tag = "R5";
        wr(0, 4'hF, mk(1, 0, 4'hF, 4, 0));
        fire_chk("R5 source zero", 0, 0, '0);
        wr(0, 4'hF, mk(1, 0, 4'hF, 0, 3));
        fire_chk("R5 destination zero", 0, 2, '0);
        wr(0, 4'hF, mk(1, 0, 4'hF, 4, 17));
        check("R10 source 17 inactive", 32'(grp_active), 32'h0);
        rnd(100);
        wr(0, 4'hF, mk(1, 0, 4'hF, 16, 16));
        check("R10 channel 16 in range", 32'(grp_active), 32'h1);
        fire_chk("R5 top channel fires", 2, 15, NCH'(1) << 15);

        tag = "R9";
        wr(0, 4'hF, mk(1, 0, 4'b0001, 6, 2));
        wr(1, 4'hF, mk(1, 0, 4'b0100, 6, 3));
        frag_done[1] = 1'b1; trsc_done[2] = 1'b1;
        @(negedge clk);
        check("R9 shared destination", 32'(chan_req), 32'(NCH'(1) << 5));
        #2;
        frag_done = '0; trsc_done = '0;
        fire_chk("R9 group1 alone", 2, 2, NCH'(1) << 5);
        wr(1, 4'b0010, mk(0, 0, 0, 11, 0));
        frag_done[1] = 1'b1; trsc_done[2] = 1'b1;
        @(negedge clk);
        check("R9 two destinations", 32'(chan_req), 32'(NCH'(1) << 5 | NCH'(1) << 10));
        #2;
        frag_done = '0; trsc_done = '0;
        rnd(300);

        tag = "R11";
        wr(0, 4'b0100, mk(0, 4'hF, 4'b0001, 0, 0));
        rd_chk("R11 mask readback", 0, 32'h01F1_0602);
        fire_chk("R11 mask does not block", 0, 1, NCH'(1) << 5);
        rnd(200);

        tag = "R4";
        for (int k = 0; k < 8; k++) begin
            wr(0, 4'hF, mk(1, 0, $urandom_range(15), $urandom_range(17), $urandom_range(17)));
            wr(1, 4'hF, mk($urandom_range(1), 0, $urandom_range(15), $urandom_range(17), $urandom_range(17)));
            rnd(150);
        end

        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule